// File: doc/BRIEF.md
# Converter Start and Byte-Read Controller

This block connects an 8-bit processor bus to a 10-bit successive-approximation converter with a parallel output. A bus write to the base address produces a start pulse of guaranteed width. The block then follows the converter's data-ready line and falls back to a fixed timeout if that line never reports completion. Bus reads of the base address and the next address fetch the two halves of the result. For each read the block drives the matching active-low byte enable, waits the converter's access time, latches the byte, releases the enable and waits the float time before it acknowledges the read.

While a conversion runs, both enables stay inactive. Any read in that time is answered at once from an internal holding register that keeps the last bytes taken from the converter. A third address returns a status byte. A sticky completion flag drives the interrupt output. Every time limit is given in nanoseconds and converted to clock cycles from the clock-period parameter. The cycle counts below assume the defaults: a 5 ns clock and base address 0x0040.

Top module: `adc_bus_ctrl`

## Requirements
- R1: While reset is active, the start output is low, both enables are high, the interrupt and the acknowledge are low, and the read data is zero.
- R2: A bus write to the base address while the block is idle raises the start output on the next clock. It stays high for exactly 100 cycles, which is 500 ns rounded up to whole cycles.
- R3: Writes to base+1 and to base+2 produce no start pulse and change no other output.
- R4: The data-ready input passes through a two-flop synchronizer. A low level on it is ignored for 300 cycles (1.5 µs) after the start output falls.
- R5: Once that window has passed, a conversion completes on the second clock after the data-ready input is sampled low. If data-ready stays high, it completes 6000 cycles (30 µs) after the start output falls.
- R6: While a conversion is busy, both enables stay high. The two enables are never low together.
- R7: A read of the base address while idle drives the high-byte enable low for 50 cycles (250 ns), latches bits 9:8 of the result and returns {6'b0, bits 9:8}. A read of base+1 does the same with the low-byte enable and returns bits 7:0.
- R8: After an enable returns high, the acknowledge follows 40 cycles (200 ns) later. The acknowledge lasts one cycle, and no new bus request is taken until the cycle after it.
- R9: A read of the base address or base+1 while busy drives neither enable. It is acknowledged one cycle later with the holding register byte: {6'b0, bits 9:8} or bits 7:0. The holding register bytes are updated only by reads from the converter.
- R10: The interrupt output is a sticky done flag. It sets when a conversion completes and clears on any accepted read of base+1.
- R11: A start write while busy is ignored and sets an error flag. A read of base+2 is acknowledged one cycle later with bit 0 = busy, bit 1 = done, bit 2 = error and zeros above, and it clears the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Bus address |
| bus_wr_i | input | 1 | One-cycle write request |
| bus_rd_i | input | 1 | One-cycle read request |
| bus_ack_o | output | 1 | Read acknowledge, one cycle |
| bus_rdata_o | output | BUS_W | Read data, valid with the acknowledge |
| adc_conv_o | output | 1 | Start pulse to the converter, active high |
| adc_rdy_i | input | 1 | Converter data-ready, high while converting |
| adc_data_i | input | RES_W | Converter parallel output |
| adc_hi_en_no | output | 1 | High-byte output enable, active low |
| adc_lo_en_no | output | 1 | Low-byte output enable, active low |
| irq_o | output | 1 | Completion interrupt, sticky |

## Verification
The hardest case to reach from the ports is a completion that the blanking window must hold back. Data-ready has to fall while it is still being ignored, and the block must then finish on the first cycle after the window rather than on the fall itself. The bench acts as the converter and drops data-ready at a programmed offset from the falling start edge. Three offsets are used: inside the window, after the window, and never, which forces the timeout. Busy-time reads and a rejected second start are placed in the middle of a conversion, so the holding register, the error flag and the status byte are all seen while the enables must stay quiet.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;

  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  typedef enum logic [1:0] {CV_IDLE, CV_START, CV_BLANK, CV_WAIT} conv_st_e;
  typedef enum logic [1:0] {RD_IDLE, RD_EN, RD_FLT, RD_ACK} rd_st_e;

endpackage

// File: rtl/adc_rdy_sync.sv
module adc_rdy_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq import adc_bus_pkg::*; #(
  parameter int unsigned PULSE_CYC = 100,
  parameter int unsigned BLANK_CYC = 300,
  parameter int unsigned TMO_CYC   = 6000  // must exceed BLANK_CYC
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rdy_i,
  output logic conv_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(TMO_CYC + 1);

  conv_st_e           st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               fin;

  // one counter spans blank and wait, so timeout is measured from the falling start edge
  assign fin    = (st_q == CV_WAIT) && (!rdy_i || cnt_q == CNT_W'(TMO_CYC - 1));
  assign conv_o = (st_q == CV_START);
  assign busy_o = (st_q != CV_IDLE);
  assign done_o = fin;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= CV_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        CV_IDLE: if (start_i) begin
          st_q  <= CV_START;
          cnt_q <= '0;
        end
        CV_START: if (cnt_q == CNT_W'(PULSE_CYC - 1)) begin
          st_q  <= CV_BLANK;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        CV_BLANK: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(BLANK_CYC - 1)) st_q <= CV_WAIT;
        end
        CV_WAIT: if (fin) st_q <= CV_IDLE;
                 else     cnt_q <= cnt_q + 1'b1;
        default: st_q <= CV_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_read_seq.sv
module adc_read_seq import adc_bus_pkg::*; #(
  parameter int unsigned ACC_CYC = 50,
  parameter int unsigned FLT_CYC = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic conv_go_i,
  input  logic quick_go_i,
  input  logic lo_sel_i,
  output logic hi_en_no,
  output logic lo_en_no,
  output logic lo_o,
  output logic cap_o,
  output logic ack_o,
  output logic idle_o
);
  localparam int unsigned MAXC  = (ACC_CYC > FLT_CYC) ? ACC_CYC : FLT_CYC;
  localparam int unsigned CNT_W = $clog2(MAXC + 1);

  rd_st_e           st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             lo_q;

  assign cap_o    = (st_q == RD_EN) && (cnt_q == CNT_W'(ACC_CYC - 1));
  assign hi_en_no = !((st_q == RD_EN) && !lo_q);
  assign lo_en_no = !((st_q == RD_EN) &&  lo_q);
  assign ack_o    = (st_q == RD_ACK);
  assign idle_o   = (st_q == RD_IDLE);
  assign lo_o     = lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= RD_IDLE;
      cnt_q <= '0;
      lo_q  <= 1'b0;
    end else begin
      case (st_q)
        RD_IDLE: if (conv_go_i) begin
          st_q  <= RD_EN;
          cnt_q <= '0;
          lo_q  <= lo_sel_i;
        end else if (quick_go_i) begin
          st_q  <= RD_ACK;
        end
        RD_EN: if (cap_o) begin
          st_q  <= RD_FLT;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        RD_FLT: if (cnt_q == CNT_W'(FLT_CYC - 1)) st_q <= RD_ACK;
                else                              cnt_q <= cnt_q + 1'b1;
        RD_ACK:  st_q <= RD_IDLE;
        default: st_q <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl import adc_bus_pkg::*; #(
  parameter int unsigned ADDR_W     = 16,
  parameter logic [15:0] BASE_ADDR  = 16'h0040,
  parameter int unsigned CLK_NS     = 5,
  parameter int unsigned START_NS   = 500,
  parameter int unsigned RDY_DLY_NS = 1500,
  parameter int unsigned CONV_NS    = 30000,
  parameter int unsigned ACCESS_NS  = 250,
  parameter int unsigned FLOAT_NS   = 200,
  parameter int unsigned RES_W      = 10,
  parameter int unsigned BUS_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  output logic              bus_ack_o,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              adc_conv_o,
  input  logic              adc_rdy_i,
  input  logic [RES_W-1:0]  adc_data_i,
  output logic              adc_hi_en_no,
  output logic              adc_lo_en_no,
  output logic              irq_o
);
  localparam int unsigned P_CYC = ns_to_cyc(START_NS, CLK_NS);
  localparam int unsigned B_CYC = ns_to_cyc(RDY_DLY_NS, CLK_NS);
  localparam int unsigned T_CYC = ns_to_cyc(CONV_NS, CLK_NS);
  localparam int unsigned A_CYC = ns_to_cyc(ACCESS_NS, CLK_NS);
  localparam int unsigned F_CYC = ns_to_cyc(FLOAT_NS, CLK_NS);
  localparam int unsigned HI_W  = RES_W - BUS_W;
  localparam int unsigned PAD_W = BUS_W - HI_W;

  logic rdy_s, conv_busy, conv_done;
  logic rd_idle, rd_lo, rd_cap;
  logic sel_hi, sel_lo, sel_st;
  logic wr_go, start, err_set, rd_go, conv_rd, quick_rd;
  logic done_q, err_q;
  logic [RES_W-1:0] hold_q;
  logic [BUS_W-1:0] rdata_q, st_byte, quick_byte, cap_byte;

  assign sel_hi = (bus_addr_i == ADDR_W'(BASE_ADDR));
  assign sel_lo = (bus_addr_i == ADDR_W'(BASE_ADDR + 16'd1));
  assign sel_st = (bus_addr_i == ADDR_W'(BASE_ADDR + 16'd2));

  // requests are taken only between read sequences
  assign wr_go    = bus_wr_i && sel_hi && rd_idle;
  assign start    = wr_go && !conv_busy;
  assign err_set  = wr_go &&  conv_busy;
  assign rd_go    = bus_rd_i && rd_idle && (sel_hi || sel_lo || sel_st);
  assign conv_rd  = rd_go && !sel_st && !conv_busy;
  assign quick_rd = rd_go && (sel_st || conv_busy);

  adc_rdy_sync #(.STAGES(2)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (adc_rdy_i),
    .q_o    (rdy_s)
  );

  adc_conv_seq #(.PULSE_CYC(P_CYC), .BLANK_CYC(B_CYC), .TMO_CYC(T_CYC)) i_conv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .rdy_i   (rdy_s),
    .conv_o  (adc_conv_o),
    .busy_o  (conv_busy),
    .done_o  (conv_done)
  );

  adc_read_seq #(.ACC_CYC(A_CYC), .FLT_CYC(F_CYC)) i_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .conv_go_i  (conv_rd),
    .quick_go_i (quick_rd),
    .lo_sel_i   (sel_lo),
    .hi_en_no   (adc_hi_en_no),
    .lo_en_no   (adc_lo_en_no),
    .lo_o       (rd_lo),
    .cap_o      (rd_cap),
    .ack_o      (bus_ack_o),
    .idle_o     (rd_idle)
  );

  assign st_byte    = BUS_W'({err_q, done_q, conv_busy});
  assign quick_byte = sel_st ? st_byte :
                      sel_lo ? hold_q[BUS_W-1:0] :
                               {{PAD_W{1'b0}}, hold_q[RES_W-1:BUS_W]};
  assign cap_byte   = rd_lo ? adc_data_i[BUS_W-1:0] :
                              {{PAD_W{1'b0}}, adc_data_i[RES_W-1:BUS_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      rdata_q <= '0;
    end else if (rd_cap) begin
      rdata_q <= cap_byte;
      if (rd_lo) hold_q[BUS_W-1:0]     <= adc_data_i[BUS_W-1:0];
      else       hold_q[RES_W-1:BUS_W] <= adc_data_i[RES_W-1:BUS_W];
    end else if (quick_rd) begin
      rdata_q <= quick_byte;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (conv_done)            done_q <= 1'b1;
      else if (rd_go && sel_lo) done_q <= 1'b0;
      if (err_set)              err_q  <= 1'b1;
      else if (rd_go && sel_st) err_q  <= 1'b0;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = done_q;
endmodule

// File: rtl/adc_bus_ctrl_chk.sv
module adc_bus_ctrl_chk #(
  parameter int unsigned PULSE_CYC = 100,
  parameter int unsigned FLT_CYC   = 40
) (
  input logic clk_i,
  input logic rst_ni,
  input logic conv_i,
  input logic busy_i,
  input logic hi_en_ni,
  input logic lo_en_ni,
  input logic ack_i,
  input logic irq_i
);
  localparam int unsigned PW = $clog2(PULSE_CYC + 2);
  localparam int unsigned GW = $clog2(FLT_CYC + 2);

  logic [PW-1:0] hi_len_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_len_q <= '0;
      gap_q    <= GW'(FLT_CYC + 1);
    end else begin
      if (conv_i) hi_len_q <= (hi_len_q == PW'(PULSE_CYC + 1)) ? hi_len_q : hi_len_q + 1'b1;
      else        hi_len_q <= '0;
      if (hi_en_ni && lo_en_ni) gap_q <= (gap_q == GW'(FLT_CYC + 1)) ? gap_q : gap_q + 1'b1;
      else                      gap_q <= '0;
    end
  end

  // R2
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(conv_i) |-> (hi_len_q >= PW'(PULSE_CYC)));

  // R6
  quiet_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (hi_en_ni && lo_en_ni));

  // R6
  one_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_en_ni || lo_en_ni));

  // R8
  float_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(hi_en_ni) || $fell(lo_en_ni)) |-> (gap_q >= GW'(FLT_CYC)));

  // R8
  ack_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !ack_i);

  // R10
  irq_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> $fell(busy_i));
endmodule

bind adc_bus_ctrl adc_bus_ctrl_chk #(.PULSE_CYC(P_CYC), .FLT_CYC(F_CYC)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .conv_i   (adc_conv_o),
  .busy_i   (conv_busy),
  .hi_en_ni (adc_hi_en_no),
  .lo_en_ni (adc_lo_en_no),
  .ack_i    (bus_ack_o),
  .irq_i    (irq_o)
);

// File: tb/test_adc_bus_ctrl.sv
`timescale 1ns/1ps
module test_adc_bus_ctrl;
  localparam int P = 100, B = 300, T = 6000, A = 50, F = 40;
  localparam int NEVER = 32'h7fff_ffff;
  localparam logic [15:0] BASE = 16'h0040;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] bus_addr_i = '0;
  logic        bus_wr_i = 1'b0, bus_rd_i = 1'b0;
  logic        bus_ack_o;
  logic [7:0]  bus_rdata_o;
  logic        adc_conv_o, adc_hi_en_no, adc_lo_en_no, irq_o;
  logic        adc_rdy_i = 1'b0;
  logic [9:0]  adc_data_i = '0;

  adc_bus_ctrl i_adc_bus_ctrl (
    .clk_i, .rst_ni, .bus_addr_i, .bus_wr_i, .bus_rd_i, .bus_ack_o, .bus_rdata_o,
    .adc_conv_o, .adc_rdy_i, .adc_data_i, .adc_hi_en_no, .adc_lo_en_no, .irq_o
  );

  always #2.5 clk_i = ~clk_i;

  int vectors = 0, fails = 0, cyc = 0;
  bit finished = 0;
  // reference model state
  int k, e, d, drop_rel = NEVER;
  bit have_k;
  int r, r_end, r_kind;  // 1 converter high, 2 converter low, 3 immediate
  bit r_have, m_irq, m_err;
  logic [7:0] exp_data;
  logic [9:0] m_hold;

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h cyc=%0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc = 0; have_k = 0; r_have = 0; m_irq = 0; m_err = 0; m_hold = '0;
    end else begin
      bit busy_pre, rd_idle, set_irq;
      cyc++;
      busy_pre = have_k && (k <= cyc - 1) && (cyc - 1 < e);
      rd_idle  = !r_have || (cyc >= r_end + 2);
      set_irq  = have_k && (cyc == e);
      if (rd_idle && bus_wr_i && bus_addr_i == BASE) begin
        if (busy_pre) m_err = 1;
        else begin
          k = cyc; have_k = 1;
          d = (drop_rel == NEVER) ? NEVER : k + P + drop_rel;
          e = (d == NEVER) ? k + P + T : ((d + 2 > k + P + B + 1) ? d + 2 : k + P + B + 1);
          if (e > k + P + T) e = k + P + T;
        end
      end
      if (rd_idle && bus_rd_i && bus_addr_i >= BASE && bus_addr_i <= BASE + 2) begin
        r = cyc; r_have = 1;
        if (bus_addr_i == BASE + 2) begin
          r_kind = 3; r_end = cyc;
          exp_data = {5'b0, m_err, m_irq, busy_pre};
          m_err = 0;
        end else if (busy_pre) begin
          r_kind = 3; r_end = cyc;
          exp_data = (bus_addr_i == BASE) ? {6'b0, m_hold[9:8]} : m_hold[7:0];
        end else if (bus_addr_i == BASE) begin
          r_kind = 1; r_end = cyc + A + F;
          exp_data = {6'b0, adc_data_i[9:8]}; m_hold[9:8] = adc_data_i[9:8];
        end else begin
          r_kind = 2; r_end = cyc + A + F;
          exp_data = adc_data_i[7:0]; m_hold[7:0] = adc_data_i[7:0];
        end
        if (bus_addr_i == BASE + 1) m_irq = 0;
      end
      if (set_irq) m_irq = 1;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      bit e_conv, e_hi, e_lo, e_ack;
      e_conv = have_k && (k <= cyc) && (cyc < k + P);
      e_hi = !(r_have && r_kind == 1 && r <= cyc && cyc < r + A);
      e_lo = !(r_have && r_kind == 2 && r <= cyc && cyc < r + A);
      e_ack = r_have && (cyc == r_end);
      chk("R2/R3 start pulse", adc_conv_o, e_conv);
      chk("R6/R7 high enable", adc_hi_en_no, e_hi);
      chk("R6/R7 low enable", adc_lo_en_no, e_lo);
      chk("R8 acknowledge", bus_ack_o, e_ack);
      chk("R4/R5/R10 interrupt", irq_o, m_irq);
      if (e_ack) chk("R7/R9/R11 read data", bus_rdata_o, exp_data);
      adc_rdy_i = have_k && (cyc + 1 > k) && (cyc + 1 < d);
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog expired act=%0d exp<150000", cyc);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  task automatic wr(logic [15:0] a);
    @(negedge clk_i); bus_addr_i = a; bus_wr_i = 1;
    @(negedge clk_i); bus_wr_i = 0;
  endtask

  task automatic rd(logic [15:0] a);
    @(negedge clk_i); bus_addr_i = a; bus_rd_i = 1;
    @(negedge clk_i); bus_rd_i = 0;
    while (cyc < r_end + 2) @(negedge clk_i);
  endtask

  task automatic wait_until(int x);
    while (cyc < x) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 start", adc_conv_o, 0);
    chk("R1 high enable", adc_hi_en_no, 1);
    chk("R1 low enable", adc_lo_en_no, 1);
    chk("R1 interrupt", irq_o, 0);
    chk("R1 acknowledge", bus_ack_o, 0);
    chk("R1 read data", bus_rdata_o, 0);
    rst_ni = 1;
    repeat (5) @(negedge clk_i);

    // R3: writes to the other addresses start nothing
    wr(BASE + 1); wr(BASE + 2);
    repeat (40) @(negedge clk_i);

    // conversion ending on data-ready after the blank window (R5)
    adc_data_i = 10'h2A5; drop_rel = 400;
    wr(BASE);
    repeat (50) @(negedge clk_i);
    rd(BASE);       // R9 busy read, holding register still zero
    rd(BASE + 2);   // R11 status shows busy
    wr(BASE);       // R11 rejected start sets error
    rd(BASE + 2);   // R11 error visible, then cleared
    wait_until(e + 3);
    rd(BASE + 2);   // done only
    rd(BASE);       // R7 high byte from converter
    rd(BASE + 1);   // R7 low byte, R10 clears interrupt

    // R4: data-ready drops inside the blank window
    adc_data_i = 10'h3C3; drop_rel = 10;
    wr(BASE);
    repeat (20) @(negedge clk_i);
    rd(BASE + 1);   // R9 busy read of low holding byte
    rd(BASE);
    wait_until(e + 3);
    rd(BASE + 1); rd(BASE);

    // R5 timeout: data-ready never drops
    adc_data_i = 10'h100; drop_rel = NEVER;
    wr(BASE);
    wait_until(e + 3);
    rd(BASE); rd(BASE + 1); rd(BASE + 2);
    repeat (20) @(negedge clk_i);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule